// File: doc/BRIEF.md
# Microaddress Trace and Breakpoint Unit

This unit sits beside a microsequenced CPU and watches the address bus of its control store. Every microcycle lasts two base clock cycles. The bus is only driven in the second of the two, so the unit samples it there. The sampled address is compared with a host-written match value, and every equality raises a one-cycle match pulse. The unit also drives the CPU's clock enable. When stop-on-match is armed, a matching sample drops that enable and freezes the CPU.

Every sampled address first becomes the "next" microaddress. When the following sample arrives, it moves into a 64-deep circular history of executed microaddresses. The current (last executed) and next addresses are always visible on output ports.

A host issues one-cycle operations. They can:
- set the match value;
- arm or disarm the stop;
- run or halt the CPU clock;
- single-step one microcycle;
- force a new microaddress onto the bus;
- read the history back newest-first.

History reads are honoured only while the CPU clock is stopped.

Top module: `uaddr_watch`

## Requirements
- R1: After reset the CPU clock enable is low, stop-on-match is disarmed, and match_pulse, force_en, rd_valid and rd_err are all low.
- R2: Host operations are given by host_op while host_op_vld is high: 0 set match value from host_data, 1 arm, 2 disarm, 3 run, 4 halt, 5 single step, 6 force address, 7 trace read. While running, a microcycle is two base cycles counted from run. The bus is sampled only on the second, so a value present only in the first base cycle is never compared. Halt abandons any partial microcycle.
- R3: A sample equal to the match value gives match_pulse high for exactly the one base cycle after the sampling edge, whether or not stop-on-match is armed.
- R4: When armed, a matching sample drops cpu_clk_en after the sampling edge. next_addr then shows the matching address and cur_addr shows the address sampled one microcycle earlier. While stopped, the bus is ignored.
- R5: Disarm (op 2) leaves the match value unchanged: later matches still pulse, and the clock keeps running.
- R6: Force (op 6) raises force_en for one cycle with force_addr equal to host_data. It replaces next_addr with host_data and disarms stop-on-match, so a later match pulses without stopping.
- R7: Single step (op 5), issued while stopped, runs exactly one microcycle and stops. cur_addr then holds the former next address and next_addr holds the sampled address.
- R8: The history keeps the 64 most recent executed microaddresses. A read (op 7) with host_data[0]=1 returns the newest. Each read with host_data[0]=0 returns the next older one, and the index wraps after 64. Data appears on rd_data with rd_valid one cycle after the request. Slots never written read as zero.
- R9: A read requested while the clock runs pulses rd_err, returns no rd_valid, and leaves the read index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_addr | input | AW | Control-store address bus being watched |
| host_op_vld | input | 1 | Host operation strobe |
| host_op | input | 3 | Host operation code |
| host_data | input | AW | Operand for match value, forced address, or read restart flag (bit 0) |
| cpu_clk_en | output | 1 | Clock enable to the CPU |
| match_pulse | output | 1 | One-cycle pulse on an address match |
| force_en | output | 1 | Strobe to drive force_addr onto the bus |
| force_addr | output | AW | Address to force |
| cur_addr | output | AW | Last executed microaddress |
| next_addr | output | AW | Microaddress about to execute |
| rd_valid | output | 1 | History read data valid |
| rd_err | output | 1 | Read refused because the clock runs |
| rd_data | output | AW | History read data |

## Verification
The bench puts the match value on the bus only in the first half of a microcycle. A design that sampled on the wrong base cycle would pulse there and miss the real second-half matches. It overfills the history past 64 entries and reads one entry beyond the depth. A wrong pointer or a missing wrap would return stale or shifted addresses, and a freshly reset history would leak garbage instead of zeros. It refuses a read while running, then reads again after the halt has pushed a new entry. A design that advanced its index on the refused read would return an entry one step too old. It also checks that a forced address disarms the stop, and that a single step stops after precisely one microcycle. A design that kept stepping would show a changed next address.

// File: rtl/uw_pkg.sv
package uw_pkg;
  typedef enum logic [2:0] {
    OP_SET_MATCH = 3'd0,
    OP_ARM       = 3'd1,
    OP_DISARM    = 3'd2,
    OP_RUN       = 3'd3,
    OP_HALT      = 3'd4,
    OP_STEP      = 3'd5,
    OP_FORCE     = 3'd6,
    OP_READ      = 3'd7
  } host_op_e;
endpackage

// File: rtl/uw_matcher.sv
module uw_matcher #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [AW-1:0] set_val,
  input  logic          sample_en,
  input  logic [AW-1:0] bus_addr,
  output logic          hit,
  output logic          pulse
);
  logic [AW-1:0] match_q;

  assign hit = sample_en && (bus_addr == match_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
      pulse   <= 1'b0;
    end else begin
      pulse <= hit;
      if (set_en) match_q <= set_val;
    end
  end

  // R3
  pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(sample_en));

  // R5
  match_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(set_en) |-> $stable(match_q));
endmodule

// File: rtl/uw_clkctl.sv
module uw_clkctl #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          do_arm,
  input  logic          do_disarm,
  input  logic          do_run,
  input  logic          do_halt,
  input  logic          do_step,
  input  logic          do_force,
  input  logic [AW-1:0] force_val,
  input  logic          hit,
  output logic          running,
  output logic          sample_en,
  output logic          force_en,
  output logic [AW-1:0] force_addr
);
  logic phase_q;
  logic armed_q;
  logic step_q;

  assign sample_en = running & phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      running    <= 1'b0;
      phase_q    <= 1'b0;
      armed_q    <= 1'b0;
      step_q     <= 1'b0;
      force_en   <= 1'b0;
      force_addr <= '0;
    end else begin
      if (running) phase_q <= ~phase_q;
      if (sample_en) begin
        if (step_q) begin
          running <= 1'b0;
          step_q  <= 1'b0;
        end else if (armed_q && hit) begin
          running <= 1'b0;
        end
      end
      if (do_arm) armed_q <= 1'b1;
      if (do_disarm || do_force) armed_q <= 1'b0;
      if (do_run && !running) running <= 1'b1;
      if (do_step && !running) begin
        running <= 1'b1;
        step_q  <= 1'b1;
      end
      if (do_halt) begin
        running <= 1'b0;
        phase_q <= 1'b0;
        step_q  <= 1'b0;
      end
      force_en <= do_force;
      if (do_force) force_addr <= force_val;
    end
  end

  // R4
  arm_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_en && armed_q && hit) |=> !running);

  // R7
  step_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_en && step_q) |=> !running);

  // R6
  force_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    force_en |-> !armed_q);

  // R2
  sample_phase_chk: assert property (@(posedge clk) disable iff (rst)
    sample_en |-> $past(running));
endmodule

// File: rtl/uw_trace.sv
module uw_trace #(
  parameter int AW    = 14,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_en,
  input  logic [AW-1:0] bus_addr,
  input  logic          force_set,
  input  logic [AW-1:0] force_val,
  input  logic          rd_req,
  input  logic          rd_restart,
  input  logic          running,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] next_addr,
  output logic          rd_valid,
  output logic          rd_err,
  output logic [AW-1:0] rd_data
);
  localparam int IW = $clog2(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [IW-1:0] wr_ptr_q;
  logic [IW:0]   fill_q;
  logic          next_vld_q;
  logic [IW-1:0] rd_idx_q;
  logic [IW-1:0] idx;
  logic [IW-1:0] raddr;
  logic [AW-1:0] rd_raw_q;
  logic          inrange_q;
  logic          push;

  assign push    = sample_en && next_vld_q;
  assign idx     = rd_restart ? '0 : rd_idx_q;
  assign raddr   = wr_ptr_q - IW'(1) - idx;
  assign rd_data = inrange_q ? rd_raw_q : '0;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= next_addr;
    rd_raw_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q   <= '0;
      fill_q     <= '0;
      next_vld_q <= 1'b0;
      next_addr  <= '0;
      cur_addr   <= '0;
      rd_idx_q   <= '0;
      rd_valid   <= 1'b0;
      rd_err     <= 1'b0;
      inrange_q  <= 1'b0;
    end else begin
      if (sample_en) begin
        next_addr  <= bus_addr;
        next_vld_q <= 1'b1;
      end
      if (push) begin
        cur_addr <= next_addr;
        wr_ptr_q <= wr_ptr_q + IW'(1);
        if (fill_q != (IW+1)'(DEPTH)) fill_q <= fill_q + (IW+1)'(1);
      end
      if (force_set) begin
        next_addr  <= force_val;
        next_vld_q <= 1'b1;
      end
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      if (rd_req) begin
        if (running) begin
          rd_err <= 1'b1;
        end else begin
          rd_valid  <= 1'b1;
          inrange_q <= ({1'b0, idx} < fill_q);
          rd_idx_q  <= idx + IW'(1);
        end
      end
    end
  end

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> $stable(rd_idx_q));

  // R9
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> !rd_valid);

  // R8
  push_order_chk: assert property (@(posedge clk) disable iff (rst)
    push |=> (cur_addr == $past(next_addr)));
endmodule

// File: rtl/uaddr_watch.sv
module uaddr_watch #(
  parameter int AW    = 14,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cs_addr,
  input  logic          host_op_vld,
  input  logic [2:0]    host_op,
  input  logic [AW-1:0] host_data,
  output logic          cpu_clk_en,
  output logic          match_pulse,
  output logic          force_en,
  output logic [AW-1:0] force_addr,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] next_addr,
  output logic          rd_valid,
  output logic          rd_err,
  output logic [AW-1:0] rd_data
);
  import uw_pkg::*;

  host_op_e op;
  logic do_set, do_arm, do_disarm, do_run, do_halt, do_step, do_force, do_read;
  logic hit, sample_en, running;

  assign op        = host_op_e'(host_op);
  assign do_set    = host_op_vld && (op == OP_SET_MATCH);
  assign do_arm    = host_op_vld && (op == OP_ARM);
  assign do_disarm = host_op_vld && (op == OP_DISARM);
  assign do_run    = host_op_vld && (op == OP_RUN);
  assign do_halt   = host_op_vld && (op == OP_HALT);
  assign do_step   = host_op_vld && (op == OP_STEP);
  assign do_force  = host_op_vld && (op == OP_FORCE);
  assign do_read   = host_op_vld && (op == OP_READ);
  assign cpu_clk_en = running;

  uw_matcher #(.AW(AW)) u_match (
    .clk(clk), .rst(rst), .set_en(do_set), .set_val(host_data),
    .sample_en(sample_en), .bus_addr(cs_addr), .hit(hit), .pulse(match_pulse)
  );

  uw_clkctl #(.AW(AW)) u_clk (
    .clk(clk), .rst(rst), .do_arm(do_arm), .do_disarm(do_disarm),
    .do_run(do_run), .do_halt(do_halt), .do_step(do_step),
    .do_force(do_force), .force_val(host_data), .hit(hit),
    .running(running), .sample_en(sample_en),
    .force_en(force_en), .force_addr(force_addr)
  );

  uw_trace #(.AW(AW), .DEPTH(DEPTH)) u_trace (
    .clk(clk), .rst(rst), .sample_en(sample_en), .bus_addr(cs_addr),
    .force_set(do_force), .force_val(host_data),
    .rd_req(do_read), .rd_restart(host_data[0]), .running(running),
    .cur_addr(cur_addr), .next_addr(next_addr),
    .rd_valid(rd_valid), .rd_err(rd_err), .rd_data(rd_data)
  );
endmodule

// File: tb/uaddr_watch_test.sv
module uaddr_watch_test;
  localparam int AW = 14;
  localparam logic [AW-1:0] NEUT = 14'h03F0;
  localparam logic [AW-1:0] MV   = 14'h0123;

  logic clk = 0;
  logic rst = 1;
  logic [AW-1:0] cs_addr = NEUT;
  logic host_op_vld = 0;
  logic [2:0] host_op = 0;
  logic [AW-1:0] host_data = 0;
  logic cpu_clk_en, match_pulse, force_en, rd_valid, rd_err;
  logic [AW-1:0] force_addr, cur_addr, next_addr, rd_data;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uaddr_watch #(.AW(AW), .DEPTH(64)) uut (
    .clk(clk), .rst(rst), .cs_addr(cs_addr), .host_op_vld(host_op_vld),
    .host_op(host_op), .host_data(host_data), .cpu_clk_en(cpu_clk_en),
    .match_pulse(match_pulse), .force_en(force_en), .force_addr(force_addr),
    .cur_addr(cur_addr), .next_addr(next_addr), .rd_valid(rd_valid),
    .rd_err(rd_err), .rd_data(rd_data)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one edge; used while stopped or for halt at a microcycle boundary
  task automatic op1(input logic [2:0] c, input logic [AW-1:0] d);
    host_op = c; host_data = d; host_op_vld = 1;
    @(negedge clk);
    host_op_vld = 0;
  endtask

  // two edges with a neutral bus: keeps microcycle alignment while running
  task automatic op2(input logic [2:0] c, input logic [AW-1:0] d);
    cs_addr = NEUT;
    op1(c, d);
    @(negedge clk);
  endtask

  task automatic mcyc(input logic [AW-1:0] a1, input logic [AW-1:0] a2, output logic p);
    cs_addr = a1;
    @(negedge clk);
    cs_addr = a2;
    @(negedge clk);
    p = match_pulse;
  endtask

  task automatic rd(input logic restart, input int exp, input string req);
    op1(3'd7, {13'd0, restart});
    check({req, " rd_valid"}, int'(rd_valid), 1);
    check({req, " rd_data"}, int'(rd_data), exp);
  endtask

  task automatic t_reset;
    check("R1 clk_en", int'(cpu_clk_en), 0);
    check("R1 match_pulse", int'(match_pulse), 0);
    check("R1 force_en", int'(force_en), 0);
    check("R1 rd_valid", int'(rd_valid), 0);
    check("R1 rd_err", int'(rd_err), 0);
  endtask

  task automatic t_fill;
    logic p;
    op1(3'd3, 0);
    mcyc(14'h500, 14'h500, p);
    mcyc(14'h501, 14'h501, p);
    mcyc(14'h502, 14'h502, p);
    op1(3'd4, 0);
    check("R8 cur", int'(cur_addr), 'h501);
    check("R8 next", int'(next_addr), 'h502);
    rd(1, 'h501, "R8 newest");
    rd(0, 'h500, "R8 older");
    rd(0, 0, "R8 unwritten zero");
  endtask

  task automatic t_match;
    logic p;
    op1(3'd0, MV);
    op1(3'd3, 0);
    check("R3 running", int'(cpu_clk_en), 1);
    mcyc(14'h10, 14'h10, p);  check("R3 no match", int'(p), 0);
    mcyc(MV, MV, p);          check("R3 match", int'(p), 1);
    mcyc(14'h11, 14'h11, p);  check("R3 one cycle", int'(p), 0);
    check("R3 not stopped", int'(cpu_clk_en), 1);
  endtask

  task automatic t_phase;
    logic p;
    mcyc(MV, 14'h22, p);  check("R2 first half ignored", int'(p), 0);
    mcyc(14'h33, MV, p);  check("R2 second half sampled", int'(p), 1);
    check("R2 next", int'(next_addr), int'(MV));
  endtask

  task automatic t_disarm;
    logic p;
    op2(3'd1, 0);
    op2(3'd2, 0);
    mcyc(MV, MV, p);
    check("R5 pulse kept", int'(p), 1);
    check("R5 running", int'(cpu_clk_en), 1);
  endtask

  task automatic t_armstop;
    logic p;
    op2(3'd1, 0);
    mcyc(14'h40, 14'h40, p);
    mcyc(MV, MV, p);
    check("R4 pulse", int'(p), 1);
    check("R4 stopped", int'(cpu_clk_en), 0);
    check("R4 next", int'(next_addr), int'(MV));
    check("R4 cur", int'(cur_addr), 'h40);
    mcyc(14'h55, 14'h55, p);
    check("R4 frozen next", int'(next_addr), int'(MV));
  endtask

  task automatic t_force;
    logic p;
    op1(3'd1, 0);
    op1(3'd6, 14'h100);
    check("R6 force_en", int'(force_en), 1);
    check("R6 force_addr", int'(force_addr), 'h100);
    check("R6 next", int'(next_addr), 'h100);
    @(negedge clk);
    check("R6 force_en one cycle", int'(force_en), 0);
    op1(3'd3, 0);
    mcyc(MV, MV, p);
    check("R6 pulse", int'(p), 1);
    check("R6 disarmed", int'(cpu_clk_en), 1);
    op1(3'd4, 0);
  endtask

  task automatic t_trace;
    logic p;
    op1(3'd6, 14'h100);
    op1(3'd3, 0);
    for (int i = 0; i < 70; i++) mcyc(AW'(14'h200 + i), AW'(14'h200 + i), p);
    op1(3'd4, 0);
    check("R8 cur after fill", int'(cur_addr), 'h244);
    rd(1, 'h244, "R8 newest");
    for (int k = 1; k < 64; k++) rd(0, 'h244 - k, "R8 history");
    rd(0, 'h244, "R8 wrap");
  endtask

  task automatic t_err;
    rd(1, 'h244, "R9 pre");
    cs_addr = 14'h777;
    op1(3'd3, 0);
    op1(3'd7, 0);
    check("R9 rd_err", int'(rd_err), 1);
    check("R9 no valid", int'(rd_valid), 0);
    op1(3'd4, 0);
    check("R9 next", int'(next_addr), 'h777);
    rd(0, 'h244, "R9 index kept");
  endtask

  task automatic t_step;
    logic p;
    op1(3'd5, 0);
    check("R7 running", int'(cpu_clk_en), 1);
    mcyc(14'h600, 14'h600, p);
    check("R7 stopped", int'(cpu_clk_en), 0);
    check("R7 cur", int'(cur_addr), 'h777);
    check("R7 next", int'(next_addr), 'h600);
    mcyc(14'h601, 14'h601, p);
    check("R7 one only", int'(next_addr), 'h600);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_fill;
    t_match;
    t_phase;
    t_disarm;
    t_armstop;
    t_force;
    t_trace;
    t_err;
    t_step;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule